// File: doc/BRIEF.md
# T1/E1 Receive Time-Slot Channel Mapper

This block sits on the receive side of one channelised T1 or E1 link, after framing recovery. It takes the recovered serial bit stream, a bit clock enable that qualifies each line bit, and a pulse that marks the first bit of every frame. For each line bit it works out which time slot the bit falls in and which bit of that slot it is. It then looks the slot up in a provisioning table. The result is a per-bit tag: a channel number, a valid flag and an octet-start flag. Downstream per-channel HDLC or transparent logic uses the tag to pick its bits out of the shared stream.

Each table entry says whether the slot is assigned. For an assigned slot, the entry gives one of 128 channel numbers and a rate option of 64 kbit/s or 56 kbit/s. Several slots may carry the same channel number, so a channel can gather any set of slots, adjacent or not, into one N×DS0 pipe. The table has two copies. Writes go into a pending copy, and the pending copy becomes the working copy only on a frame start. The link type (T1 or E1) is also taken only on a frame start.

Top module: `ts_chan_mapper`

## Requirements
- R1: After reset all outputs are 0. No bit is marked valid until the first frame-start pulse is seen with `bit_en` high.
- R2: In E1 mode, frame bit p (p = 0 on the bit that carries the frame-start pulse) belongs to slot p/8 and is bit p%8 of that slot. Slot 0 (bits 0..7) is never marked valid, whatever its table entry holds.
- R3: In T1 mode, frame bit 0 is the framing bit and is never marked valid. Bit p ≥ 1 belongs to slot (p-1)/8+1 and is bit (p-1)%8 of that slot, for slots 1..24.
- R4: A slot whose entry has `cfg_assign` = 0 never yields a valid bit. Whenever `out_valid` is 0, `out_chan` is 0.
- R5: For a valid bit, `out_chan` equals the channel number stored for its slot. Slots that hold the same number, adjacent or not, all yield that number.
- R6: In a slot with `cfg_56k` = 1, only bits 0..6 are valid and bit 7 is not. In a slot with `cfg_56k` = 0, all eight bits are valid.
- R7: `out_octet_start` is 1 exactly on a valid bit that is bit 0 of its slot, so octets line up with slot boundaries.
- R8: A table write is applied at the next frame start after it. If the write falls in the same cycle as a frame start, it is applied at the frame start after that. Bits of the current frame keep the old assignment.
- R9: The outputs for a line bit appear one clock after the cycle in which `bit_en` was high, and `out_bit` repeats that line bit. `out_valid` and `out_octet_start` are 0 in any cycle that follows a cycle with `bit_en` low.
- R10: Bits beyond the frame length (bit 256 onward for E1, bit 193 onward for T1) are never valid until the next frame start. Table entries for slots 25..31 have no effect in T1 mode.
- R11: `e1_mode` is sampled only on the frame-start bit. A change of `e1_mode` within a frame does not alter the mapping of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `line_bit` and `frame_start` for this cycle |
| frame_start | input | 1 | Marks the current line bit as bit 0 of a frame |
| line_bit | input | 1 | Received serial data bit |
| e1_mode | input | 1 | 1 = E1 (32 slots, 256 bits), 0 = T1 (24 slots plus framing bit, 193 bits) |
| cfg_we | input | 1 | Writes one entry of the pending table |
| cfg_slot | input | 5 | Slot index of the written entry |
| cfg_assign | input | 1 | 1 = slot carries a channel |
| cfg_56k | input | 1 | 1 = 56 kbit/s slot (bit 7 unused) |
| cfg_chan | input | 7 | Channel number for the slot |
| out_valid | output | 1 | Tagged bit belongs to an assigned channel |
| out_bit | output | 1 | The line bit, delayed by one clock |
| out_octet_start | output | 1 | Tagged bit is the first bit of its slot |
| out_chan | output | 7 | Channel number of the tagged bit, 0 when not valid |

## Verification
The assertions check rules that hold on every cycle, whatever the table contents. Valid only follows an enabled bit, and the output bit copies the line. An octet start never appears without valid. The channel field is zero when idle. The frame-start bit itself is never valid. The bench's scenarios are needed for the rules that depend on position and history. These are the E1 and T1 slot arithmetic, the 56 kbit/s masking of bit 7, and non-adjacent slots sharing a channel. They also cover the out-of-frame tail, and a pending write or a mode change mid-frame leaving the running frame untouched.

// File: rtl/ts_chan_mapper.sv
module ts_chan_mapper #(
  parameter int CHAN_W   = 7,
  parameter int SLOTS    = 32,
  parameter int T1_SLOTS = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_en,
  input  logic                     frame_start,
  input  logic                     line_bit,
  input  logic                     e1_mode,
  input  logic                     cfg_we,
  input  logic [$clog2(SLOTS)-1:0] cfg_slot,
  input  logic                     cfg_assign,
  input  logic                     cfg_56k,
  input  logic [CHAN_W-1:0]        cfg_chan,
  output logic                     out_valid,
  output logic                     out_bit,
  output logic                     out_octet_start,
  output logic [CHAN_W-1:0]        out_chan
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int POS_W  = SLOT_W + 4;
  localparam int ENT_W  = CHAN_W + 2;
  localparam logic [POS_W-1:0] E1_END = POS_W'(SLOTS * 8);
  localparam logic [POS_W-1:0] T1_END = POS_W'(T1_SLOTS * 8 + 1);

  logic [ENT_W-1:0] shadow_q [SLOTS];
  logic [ENT_W-1:0] active_q [SLOTS];
  logic [POS_W-1:0] pos_q;
  logic             e1_q;

  wire              fs    = bit_en & frame_start;
  wire [POS_W-1:0]  pos   = fs ? '0 : pos_q;
  wire              e1    = fs ? e1_mode : e1_q;
  wire [POS_W-2:0]  tpos  = pos[POS_W-2:0] - 1'b1;
  wire [SLOT_W-1:0] slot  = e1 ? pos[SLOT_W+2:3] : tpos[SLOT_W+2:3] + 1'b1;
  wire [2:0]        bitn  = e1 ? pos[2:0] : tpos[2:0];
  wire              in_fr = e1 ? (pos < E1_END && slot != '0)
                               : (pos != '0 && pos < T1_END);
  wire [ENT_W-1:0]  ent   = active_q[slot];
  wire              hit   = bit_en & in_fr & ent[ENT_W-1]
                            & ~(ent[ENT_W-2] & (bitn == 3'd7));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q           <= '1;
      e1_q            <= 1'b0;
      out_valid       <= 1'b0;
      out_bit         <= 1'b0;
      out_octet_start <= 1'b0;
      out_chan        <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end
    end else begin
      if (bit_en) begin
        pos_q <= (pos == '1) ? pos : pos + 1'b1;
        if (fs) e1_q <= e1_mode;
      end
      if (fs)
        for (int i = 0; i < SLOTS; i++) active_q[i] <= shadow_q[i];
      if (cfg_we) shadow_q[cfg_slot] <= {cfg_assign, cfg_56k, cfg_chan};
      out_valid       <= hit;
      out_bit         <= line_bit;
      out_octet_start <= hit & (bitn == 3'd0);
      out_chan        <= hit ? ent[CHAN_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/ts_chan_mapper_chk.sv
module ts_chan_mapper_chk #(
  parameter int CHAN_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              frame_start,
  input logic              line_bit,
  input logic              out_valid,
  input logic              out_bit,
  input logic              out_octet_start,
  input logic [CHAN_W-1:0] out_chan
);
  p_valid_after_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en == 1'b0 |=> !out_valid && !out_octet_start);

  p_bit_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> out_bit == $past(line_bit));

  p_octet_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_octet_start |-> out_valid);

  p_idle_chan_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_chan == '0);

  p_framing_bit_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && frame_start |=> !out_valid);
endmodule

bind ts_chan_mapper ts_chan_mapper_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
  .line_bit(line_bit), .out_valid(out_valid), .out_bit(out_bit),
  .out_octet_start(out_octet_start), .out_chan(out_chan)
);

// File: tb/tb_ts_chan_mapper.sv
module tb_ts_chan_mapper;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, frame_start = 1'b0, line_bit = 1'b0, e1_mode = 1'b0;
  logic       cfg_we = 1'b0, cfg_assign = 1'b0, cfg_56k = 1'b0;
  logic [4:0] cfg_slot = '0;
  logic [6:0] cfg_chan = '0;
  logic       out_valid, out_bit, out_octet_start;
  logic [6:0] out_chan;

  ts_chan_mapper dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .line_bit(line_bit), .e1_mode(e1_mode), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_assign(cfg_assign), .cfg_56k(cfg_56k), .cfg_chan(cfg_chan),
    .out_valid(out_valid), .out_bit(out_bit), .out_octet_start(out_octet_start),
    .out_chan(out_chan)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit en; bit k56; int ch; } ent_t;
  typedef struct { bit v; bit oct; bit b; int ch; string tag; string scen; } item_t;

  ent_t  m_sh [32];
  ent_t  m_act [32];
  bit    m_e1 = 1'b0;
  bit    m_sync = 1'b0;
  int    m_cnt = 511;
  item_t exp_q [$];
  string scen = "R1";
  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  logic  en_q = 1'b0;

  task automatic drv_bit(input bit fs, input bit b, input bit mode);
    item_t it;
    int pos, slot, bn;
    bit ok;
    @(negedge clk);
    bit_en = 1'b1; frame_start = fs; line_bit = b; e1_mode = mode; cfg_we = 1'b0;
    if (fs) begin m_act = m_sh; m_e1 = mode; m_sync = 1'b1; pos = 0; end
    else pos = m_cnt;
    m_cnt = (pos == 511) ? 511 : pos + 1;
    ok = 1'b0; slot = 0; bn = 0;
    if (!m_sync) it.tag = "R1";
    else if (m_e1) begin
      slot = pos / 8; bn = pos % 8;
      if (pos >= 256) it.tag = "R10";
      else if (slot == 0) it.tag = "R2";
      else ok = 1'b1;
    end else begin
      if (pos == 0) it.tag = "R3";
      else if (pos >= 193) it.tag = "R10";
      else begin slot = (pos - 1) / 8 + 1; bn = (pos - 1) % 8; ok = 1'b1; end
    end
    it.v = 1'b0;
    if (ok) begin
      if (!m_act[slot].en) it.tag = "R4";
      else if (m_act[slot].k56 && bn == 7) it.tag = "R6";
      else begin it.v = 1'b1; it.tag = (bn == 0) ? "R7" : "R5"; end
    end
    it.ch = it.v ? m_act[slot].ch : 0;
    it.oct = it.v && bn == 0;
    it.b = b;
    it.scen = scen;
    exp_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    bit_en = 1'b0; frame_start = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg(input int slot, input bit en, input bit k56, input int ch);
    @(negedge clk);
    bit_en = 1'b0; frame_start = 1'b0;
    cfg_we = 1'b1; cfg_slot = 5'(slot); cfg_assign = en; cfg_56k = k56; cfg_chan = 7'(ch);
    m_sh[slot].en = en; m_sh[slot].k56 = k56; m_sh[slot].ch = en ? ch : m_sh[slot].ch;
    if (!en) m_sh[slot].ch = ch;
  endtask

  // Sends nbits bits starting with a frame start; optional gaps, mode flip, mid-frame write.
  task automatic send_frame(input bit mode, input int nbits, input int gap_every,
                            input bit flip, input int wr_at);
    for (int i = 0; i < nbits; i++) begin
      drv_bit(i == 0, bit'(((i * 7 + 3) % 5) < 2),
              (flip && i >= nbits / 2) ? !mode : mode);
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) idle();
      if (i == wr_at) begin
        cfg(2, 1'b1, 1'b0, 3);   // R8: pending only
        cfg(1, 1'b0, 1'b0, 0);   // R8: pending only
      end
    end
  endtask

  always @(posedge clk) en_q <= bit_en;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (en_q) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9: output for a bit with no expected entry, valid=%0b expected none",
                   out_valid);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          if (out_valid !== e.v || out_chan !== 7'(e.ch) ||
              out_octet_start !== e.oct || out_bit !== e.b) begin
            errors++;
            $display("FAIL %s [%s]: valid=%0b chan=%0d oct=%0b bit=%0b expected valid=%0b chan=%0d oct=%0b bit=%0b",
                     e.tag, e.scen, out_valid, out_chan, out_octet_start, out_bit,
                     e.v, e.ch, e.oct, e.b);
          end
        end
      end else begin
        checks++;
        if (out_valid !== 1'b0 || out_octet_start !== 1'b0) begin
          errors++;
          $display("FAIL R9: idle cycle valid=%0b oct=%0b expected valid=0 oct=0",
                   out_valid, out_octet_start);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_sh[i] = '{0, 0, 0}; m_act[i] = '{0, 0, 0}; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_bit !== 1'b0 || out_octet_start !== 1'b0 || out_chan !== 7'd0) begin
      errors++;
      $display("FAIL R1: after reset valid=%0b bit=%0b oct=%0b chan=%0d expected all 0",
               out_valid, out_bit, out_octet_start, out_chan);
    end

    // R1: assigned slots but no frame start yet
    cfg(1, 1'b1, 1'b0, 5);
    scen = "R1";
    for (int i = 0; i < 20; i++) drv_bit(1'b0, bit'(i & 1), 1'b1);

    // R2 R5 R6: E1 with non-adjacent slots sharing channel 5, slot 0 entry ignored
    cfg(0, 1'b1, 1'b0, 9);
    cfg(3, 1'b1, 1'b1, 5);
    cfg(31, 1'b1, 1'b0, 127);
    cfg(17, 1'b1, 1'b1, 0);
    scen = "E1 base, R11 mode flip";
    send_frame(1'b1, 256, 7, 1'b1, -1);

    // R8: writes in mid frame leave this frame unchanged
    scen = "R8 write mid-frame";
    send_frame(1'b1, 256, 0, 1'b0, 100);

    // R8 applied; R10 tail past bit 255
    scen = "R8 applied, R10 tail";
    send_frame(1'b1, 276, 11, 1'b0, -1);

    // T1: slot 24 last, slot 25 entry ignored (R10), 56k slot 12
    cfg(24, 1'b1, 1'b0, 64);
    cfg(25, 1'b1, 1'b0, 1);
    cfg(12, 1'b1, 1'b1, 5);
    cfg(3, 1'b0, 1'b0, 0);
    scen = "T1 R3";
    send_frame(1'b0, 193 + 15, 9, 1'b0, -1);
    scen = "T1 R11 mode flip";
    send_frame(1'b0, 193, 0, 1'b1, -1);
    scen = "E1 after T1";
    send_frame(1'b1, 256, 13, 1'b0, -1);

    repeat (4) idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d expected outputs never produced, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule